// File: doc/BRIEF.md
# TDM Frame Pulse Classifier and Bit Timing Generator

This block sits at the receive edge of a time-division-multiplexed serial port. The bit clock of the port (`mclk_in`) runs at twice the serial data rate, so each bit cell spans two of its periods. The frame pulse (`fp_in`) repeats once per frame. The block works in a fast system clock domain. It finds the edges of the bit clock by oversampling it, and it samples the frame pulse and the serial data at those edges. For this reason the bit clock must stay well below the system clock.

With `wide_mode` low, the block works out the framing convention from the frame pulse itself. An active-low pulse seen on falling edges of the bit clock selects the negative convention: bit boundaries fall on falling edges and data is taken on rising edges. An active-high pulse seen on rising edges selects the positive convention, which uses the opposite edges. With `wide_mode` high, the pulse is taken as active high and is seen on falling edges, and the negative-convention edge timing applies.

Once the block is aligned, it emits a one-cycle strobe at each bit boundary and a one-cycle strobe three quarters of the way through each bit cell. It captures the data bit at the second of these. It also keeps a bit-in-channel counter and a channel counter, and reports which format it has locked to. The default frame is 32 channels of 8 bits, which is 256 bits per frame at 2.048 Mb/s. Larger frames for faster line rates come from the parameters.

Top module: `tdm_frame_aligner`

## Requirements
- R1: After a synchronous reset, `fmt_code` is 0 (none), `locked` is 0, both strobes are 0, and `rx_bit`, `bit_cnt` and `chan_cnt` are 0.
- R2: With `wide_mode` low and no format held, a falling `mclk_in` edge with `fp_in` low, where the previous falling edge saw it high, locks the negative format. Then `fmt_code` becomes 1, `locked` becomes 1, `bit_strobe` pulses, and both counters restart at 0.
- R3: With `wide_mode` low and no format held, a rising `mclk_in` edge with `fp_in` high, where the previous rising edge saw it low, locks the positive format. Then `fmt_code` becomes 2, with the same strobe and counter restart.
- R4: While locked, `bit_strobe` is high for one system cycle after every second boundary-type edge. Falling edges are the boundary type for formats 1 and 3, and rising edges for format 2. The edge carrying the frame pulse counts as a boundary.
- R5: `sample_strobe` is high for one system cycle after the opposite-type edge that lies 1.5 bit-clock periods past each boundary. At that edge, `rx_bit` takes the value of `sdata_in` and holds it until the next sample.
- R6: `bit_cnt` steps through 0 to BITS_PER_CHAN-1 at each boundary. `chan_cnt` steps at each `bit_cnt` wrap, and both return to 0 after the last bit of the last channel.
- R7: A valid frame pulse that arrives anywhere in the frame restarts `bit_cnt`, `chan_cnt` and the bit phase from 0.
- R8: Once a format is held, the pulse pattern of the other format is ignored. The trailing edge of a positive pulse looks like a negative pulse, and it leaves the counters running.
- R9: If no valid pulse arrives on 2·BITS_PER_CHAN·CHANS+1 consecutive boundary-type edges, `locked` and `fmt_code` return to 0 and the counters clear. While unlocked, no strobe is issued.
- R10: With `wide_mode` high, a falling edge with `fp_in` high, where the previous falling edge saw it low, locks format 3.
- R11: Any change of `wide_mode` drops lock and clears `fmt_code` and the counters. No pulse is accepted in the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_in | input | 1 | Bit clock at twice the serial data rate |
| fp_in | input | 1 | Frame pulse |
| wide_mode | input | 1 | 0: auto-detect the narrow format, 1: wide pulse alignment |
| sdata_in | input | 1 | Serial receive data |
| fmt_code | output | 2 | 0 none, 1 negative, 2 positive, 3 wide |
| locked | output | 1 | Frame alignment held |
| bit_strobe | output | 1 | Bit boundary strobe |
| sample_strobe | output | 1 | Three-quarter-cell sample strobe |
| rx_bit | output | 1 | Last sampled data bit |
| bit_cnt | output | $clog2(BITS_PER_CHAN) | Bit index within the channel |
| chan_cnt | output | $clog2(CHANS) | Channel index within the frame |

## Verification
The hardest state to reach is loss of lock. It needs a full frame and one more boundary edge with no valid pulse, and the frame pulse must never show a level change that the held format would accept. The stimulus keeps the pulse at its idle level for longer than a frame after a run of aligned frames. It then moves the idle level from high to low only inside a reset, because a high-to-low step seen at a falling edge would otherwise lock the negative format. The same trailing edge of a positive pulse is used on purpose once that format is held, to show it is ignored.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_NEG  = 2'd1,
    FMT_POS  = 2'd2,
    FMT_WIDE = 2'd3
  } fmt_e;
endpackage

// File: rtl/tfa_edge_sampler.sv
module tfa_edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic mclk_in,
  output logic rise,
  output logic fall
);
  logic mclk_q;

  always_ff @(posedge clk) begin
    if (rst) mclk_q <= 1'b0;
    else     mclk_q <= mclk_in;
  end

  assign rise = mclk_in & ~mclk_q;
  assign fall = ~mclk_in & mclk_q;
endmodule

// File: rtl/tfa_format_lock.sv
module tfa_format_lock
  import tfa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  localparam int MISS_LIMIT = 2 * FRAME_BITS,
  localparam int MISS_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fall,
  input  logic fp,
  input  logic wide,
  output logic frame_evt,
  output logic drop,
  output fmt_e fmt_o,
  output logic locked_o
);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT);

  logic fpf_prev, fpr_prev, mode_q, locked_q;
  fmt_e fmt_q, fmt_nx;
  logic [MISS_W-1:0] miss_q;
  logic neg_evt, pos_evt, wid_evt, mode_chg, bnd_edge, miss_out;

  assign neg_evt  = fall & fpf_prev & ~fp;
  assign pos_evt  = rise & ~fpr_prev & fp;
  assign wid_evt  = fall & ~fpf_prev & fp;
  assign mode_chg = wide ^ mode_q;
  assign bnd_edge = (fmt_q == FMT_POS) ? rise : fall;

  always_comb begin
    frame_evt = 1'b0;
    fmt_nx    = fmt_q;
    if (!mode_chg) begin
      if (wide) begin
        frame_evt = wid_evt;
        fmt_nx    = FMT_WIDE;
      end else begin
        unique case (fmt_q)
          FMT_NONE: begin
            if (neg_evt) begin
              frame_evt = 1'b1;
              fmt_nx    = FMT_NEG;
            end else if (pos_evt) begin
              frame_evt = 1'b1;
              fmt_nx    = FMT_POS;
            end
          end
          FMT_NEG: frame_evt = neg_evt;
          FMT_POS: frame_evt = pos_evt;
          default: frame_evt = 1'b0;
        endcase
      end
    end
  end

  assign miss_out = locked_q & bnd_edge & ~frame_evt & ~mode_chg & (miss_q == MISS_LAST);
  assign drop     = mode_chg | miss_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      fpf_prev <= 1'b0;
      fpr_prev <= 1'b1;
      mode_q   <= 1'b0;
      fmt_q    <= FMT_NONE;
      locked_q <= 1'b0;
      miss_q   <= '0;
    end else begin
      mode_q <= wide;
      if (fall) fpf_prev <= fp;
      if (rise) fpr_prev <= fp;
      if (drop) begin
        fmt_q    <= FMT_NONE;
        locked_q <= 1'b0;
        miss_q   <= '0;
      end else if (frame_evt) begin
        fmt_q    <= fmt_nx;
        locked_q <= 1'b1;
        miss_q   <= '0;
      end else if (locked_q && bnd_edge) begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end

  assign fmt_o    = fmt_q;
  assign locked_o = locked_q;

  assert_fmt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !drop) |=> $stable(fmt_q));

  assert_miss_bound_R9: assert property (@(posedge clk) disable iff (rst)
    miss_q <= MISS_LAST);

  assert_mode_drop_R11: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !locked_q);
endmodule

// File: rtl/tfa_bit_timer.sv
module tfa_bit_timer #(
  parameter int BITS_PER_CHAN = 8,
  parameter int CHANS = 32,
  localparam int BIT_W = $clog2(BITS_PER_CHAN),
  localparam int CH_W = $clog2(CHANS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             fall,
  input  logic             frame_evt,
  input  logic             drop,
  input  logic             locked,
  input  logic             sdata,
  output logic             bnd_stb,
  output logic             smp_stb,
  output logic             rx_bit,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [CH_W-1:0]  chan_cnt
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_CHAN - 1);
  localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANS - 1);

  logic [1:0] phase_q;
  logic       any_edge;

  assign any_edge = rise | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 2'd0;
      bit_cnt  <= '0;
      chan_cnt <= '0;
      bnd_stb  <= 1'b0;
      smp_stb  <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      bnd_stb <= 1'b0;
      smp_stb <= 1'b0;
      if (drop) begin
        phase_q  <= 2'd0;
        bit_cnt  <= '0;
        chan_cnt <= '0;
      end else if (any_edge && frame_evt) begin
        phase_q  <= 2'd0;
        bit_cnt  <= '0;
        chan_cnt <= '0;
        bnd_stb  <= 1'b1;
      end else if (any_edge && locked) begin
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd3) begin
          bnd_stb <= 1'b1;
          if (bit_cnt == BIT_LAST) begin
            bit_cnt  <= '0;
            chan_cnt <= (chan_cnt == CH_LAST) ? '0 : chan_cnt + 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (phase_q == 2'd2) begin
          smp_stb <= 1'b1;
          rx_bit  <= sdata;
        end
      end
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(bnd_stb && smp_stb));

  assert_sample_single_R5: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> !smp_stb);

  assert_bnd_single_R4: assert property (@(posedge clk) disable iff (rst)
    bnd_stb |=> !bnd_stb);
endmodule

// File: rtl/tdm_frame_aligner.sv
module tdm_frame_aligner
  import tfa_pkg::*;
#(
  parameter int BITS_PER_CHAN = 8,
  parameter int CHANS = 32,
  localparam int BIT_W = $clog2(BITS_PER_CHAN),
  localparam int CH_W = $clog2(CHANS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclk_in,
  input  logic             fp_in,
  input  logic             wide_mode,
  input  logic             sdata_in,
  output logic [1:0]       fmt_code,
  output logic             locked,
  output logic             bit_strobe,
  output logic             sample_strobe,
  output logic             rx_bit,
  output logic [BIT_W-1:0] bit_cnt,
  output logic [CH_W-1:0]  chan_cnt
);
  localparam int FRAME_BITS = BITS_PER_CHAN * CHANS;

  logic rise, fall, frame_evt, drop;
  fmt_e fmt;

  tfa_edge_sampler u_edge (
    .clk     (clk),
    .rst     (rst),
    .mclk_in (mclk_in),
    .rise    (rise),
    .fall    (fall)
  );

  tfa_format_lock #(.FRAME_BITS(FRAME_BITS)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .fall      (fall),
    .fp        (fp_in),
    .wide      (wide_mode),
    .frame_evt (frame_evt),
    .drop      (drop),
    .fmt_o     (fmt),
    .locked_o  (locked)
  );

  tfa_bit_timer #(.BITS_PER_CHAN(BITS_PER_CHAN), .CHANS(CHANS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .fall      (fall),
    .frame_evt (frame_evt),
    .drop      (drop),
    .locked    (locked),
    .sdata     (sdata_in),
    .bnd_stb   (bit_strobe),
    .smp_stb   (sample_strobe),
    .rx_bit    (rx_bit),
    .bit_cnt   (bit_cnt),
    .chan_cnt  (chan_cnt)
  );

  assign fmt_code = fmt;

  assert_lock_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (bit_strobe && bit_cnt == '0 && chan_cnt == '0));

  assert_unlocked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (!bit_strobe && !sample_strobe));
endmodule

// File: tb/tdm_frame_aligner_test.sv
module tdm_frame_aligner_test;
  localparam int BPC = 8;
  localparam int CH = 32;
  localparam int FB = BPC * CH;
  localparam int LIMIT = 2 * FB;
  localparam int HALVES = 4 * FB;

  logic clk = 1'b0, rst = 1'b1, mclk = 1'b0, fp = 1'b1, wide = 1'b0, sd = 1'b0;
  logic [1:0] fmt_code;
  logic locked, bit_strobe, sample_strobe, rx_bit;
  logic [2:0] bit_cnt;
  logic [4:0] chan_cnt;

  tdm_frame_aligner #(.BITS_PER_CHAN(BPC), .CHANS(CH)) uut (
    .clk(clk), .rst(rst), .mclk_in(mclk), .fp_in(fp), .wide_mode(wide),
    .sdata_in(sd), .fmt_code(fmt_code), .locked(locked), .bit_strobe(bit_strobe),
    .sample_strobe(sample_strobe), .rx_bit(rx_bit), .bit_cnt(bit_cnt), .chan_cnt(chan_cnt)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R1";
  logic cur_wide = 1'b0, cur_rst = 1'b1;
  logic [31:0] seed = 32'h1234_5678;

  // behavioural reference state
  int m_fmt = 0, m_locked = 0, m_h = 0, m_miss = 0, m_bnd = 0, m_smp = 0, m_rx = 0;
  int m_mq = 0, m_fpf = 0, m_fpr = 1, m_mode = 0;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(req, "fmt_code", int'(fmt_code), m_fmt);
    chk(req, "locked", int'(locked), m_locked);
    chk(req, "bit_strobe", int'(bit_strobe), m_bnd);
    chk(req, "sample_strobe", int'(sample_strobe), m_smp);
    chk(req, "rx_bit", int'(rx_bit), m_rx);
    chk(req, "bit_cnt", int'(bit_cnt), (m_h / 4) % BPC);
    chk(req, "chan_cnt", int'(chan_cnt), m_h / (4 * BPC));
  endtask

  task automatic model(int mc, int f, int d, int w, int r);
    int rise, fall, evt, drop, nfmt, bedge, neg, pos, wid;
    rise = (mc == 1 && m_mq == 0);
    fall = (mc == 0 && m_mq == 1);
    m_bnd = 0; m_smp = 0;
    if (r != 0) begin
      m_fmt = 0; m_locked = 0; m_h = 0; m_miss = 0; m_rx = 0;
      m_mq = 0; m_fpf = 0; m_fpr = 1; m_mode = 0;
      return;
    end
    evt = 0; drop = 0; nfmt = m_fmt;
    neg = fall && m_fpf == 1 && f == 0;
    pos = rise && m_fpr == 0 && f == 1;
    wid = fall && m_fpf == 0 && f == 1;
    bedge = (m_fmt == 2) ? rise : fall;
    if (w != m_mode) drop = 1;
    else if (w == 1) begin evt = wid; nfmt = 3; end
    else if (m_fmt == 0) begin
      if (neg) begin evt = 1; nfmt = 1; end
      else if (pos) begin evt = 1; nfmt = 2; end
    end
    else if (m_fmt == 1) evt = neg;
    else if (m_fmt == 2) evt = pos;
    if (!drop && !evt && m_locked == 1 && bedge) begin
      if (m_miss == LIMIT) drop = 1;
      else m_miss++;
    end
    if (drop) begin
      m_fmt = 0; m_locked = 0; m_h = 0; m_miss = 0;
    end else if (evt) begin
      m_fmt = nfmt; m_locked = 1; m_h = 0; m_miss = 0; m_bnd = 1;
    end else if ((rise || fall) && m_locked == 1) begin
      m_h = (m_h + 1) % HALVES;
      m_bnd = (m_h % 4 == 0);
      m_smp = (m_h % 4 == 3);
      if (m_smp == 1) m_rx = d;
    end
    if (fall) m_fpf = f;
    if (rise) m_fpr = f;
    m_mq = mc;
    m_mode = w;
  endtask

  task automatic step(logic mc, logic f);
    logic d;
    @(negedge clk);
    compare();
    seed = seed * 32'd1103515245 + 32'd12345;
    d = seed[16];
    mclk = mc; fp = f; sd = d; wide = cur_wide; rst = cur_rst;
    model(int'(mc), int'(f), int'(d), int'(cur_wide), int'(cur_rst));
  endtask

  // one bit-clock period: fr is the pulse level at the rising edge, ff at the falling edge
  task automatic period(logic fr, logic ff);
    step(1'b1, fr); step(1'b1, fr); step(1'b0, ff); step(1'b0, ff);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    req = "R1";
    cur_rst = 1'b1;
    repeat (4) step(1'b0, 1'b1);
    chk("R1", "locked after reset", int'(locked), 0);
    chk("R1", "fmt after reset", int'(fmt_code), 0);
    cur_rst = 1'b0;

    // R2: active-low pulse at a falling edge
    req = "R2";
    repeat (3) period(1'b1, 1'b1);
    period(1'b1, 1'b0);
    chk("R2", "fmt negative", int'(fmt_code), 1);
    chk("R2", "locked", int'(locked), 1);

    // R4 R5 R6: two aligned frames
    req = "R4 R5 R6";
    for (int fr = 0; fr < 2; fr++) begin
      for (int p = 1; p < 2 * FB; p++) period(1'b1, 1'b1);
      period(1'b1, 1'b0);
    end

    // R7: early pulse realigns
    req = "R7";
    repeat (100) period(1'b1, 1'b1);
    period(1'b1, 1'b0);
    chk("R7", "bit_cnt after early pulse", int'(bit_cnt), 0);
    for (int p = 1; p < 2 * FB; p++) period(1'b1, 1'b1);
    period(1'b1, 1'b0);

    // R9: pulses stop, lock is lost after a frame plus one edge
    req = "R9";
    repeat (2 * FB + 20) period(1'b1, 1'b1);
    chk("R9", "locked after loss", int'(locked), 0);
    chk("R9", "fmt after loss", int'(fmt_code), 0);

    // move idle level low inside reset (R1 again)
    req = "R1";
    cur_rst = 1'b1;
    repeat (4) step(1'b0, 1'b0);
    cur_rst = 1'b0;

    // R3: active-high pulse at a rising edge
    req = "R3";
    repeat (3) period(1'b0, 1'b0);
    period(1'b1, 1'b1);
    chk("R3", "fmt positive", int'(fmt_code), 2);
    // R8: trailing edge of the high pulse mimics a negative pulse
    req = "R8";
    period(1'b0, 1'b0);
    chk("R8", "fmt kept", int'(fmt_code), 2);
    chk("R8", "phase not restarted (bit_cnt)", int'(bit_cnt), 0);
    for (int p = 2; p < 2 * FB; p++) period(1'b0, 1'b0);
    period(1'b1, 1'b1);
    repeat (300) period(1'b0, 1'b0);

    // R11: mode change drops lock
    req = "R11";
    cur_wide = 1'b1;
    period(1'b0, 1'b0);
    chk("R11", "locked after mode change", int'(locked), 0);
    chk("R11", "chan_cnt after mode change", int'(chan_cnt), 0);

    // R10: wide mode pulse
    req = "R10";
    repeat (3) period(1'b0, 1'b0);
    period(1'b0, 1'b1);
    chk("R10", "fmt wide", int'(fmt_code), 3);
    for (int p = 1; p < 2 * FB; p++) period(1'b0, 1'b0);
    period(1'b0, 1'b1);
    repeat (400) period(1'b0, 1'b0);

    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule